// File: doc/BRIEF.md
# Multi-Channel Pulse-Per-Second Timestamper

This block timestamps the rising edges of several once-per-second pulse inputs against one shared free-running counter that runs on the system clock. Typical inputs are divided-down outputs of frequency standards under test, plus the pulse output of a GPS timing receiver. Because every channel reads the same timebase, subtracting two timestamps taken in the same second gives the phase offset between those two sources directly, with no counter-to-counter skew.

Each input passes through a two-stage synchronizer and a rising-edge detector. Each detected edge latches the counter value into that channel's own capture slot and raises a pending flag. A small arbiter moves pending slots into a 16-entry FIFO, one per cycle, lowest channel number first. A host drains the FIFO by reading one fixed data address again and again, and polls a status word that reports emptiness, fill level and a sticky overflow flag.

Top module: `pps_timestamper`

## Requirements
- R1: A single counter, cleared to 0 by reset, increments by one on every clock and serves as the timebase for all channels. An input that goes high in the clock cycle in which the bench's own count of clocks since reset is c yields the timestamp c+2 (two synchronizer stages, then the capture register).
- R2: Each input is synchronized by two flip-flops and produces exactly one sample per low-to-high transition, however long it then stays high.
- R3: The timestamp of an edge is the counter value latched in that channel's capture slot, so two edges d cycles apart on different channels carry timestamps that differ by d.
- R4: Edges that arrive on several channels in the same cycle are written into the FIFO one per cycle in ascending channel order, each carrying the same timestamp.
- R5: The FIFO holds 16 entries and returns them in arrival order. The status word (address 1) carries empty in bit 0 and the fill count (0 to 16) in bits 12:8.
- R6: A read of the data address (address 0) returns the head entry, with the channel number in bits 34:32 and the timestamp in bits 31:0, and pops it. A read while the FIFO is empty returns 0 and leaves the fill count unchanged.
- R7: A write dropped because the FIFO is full sets the overflow flag (status bit 1), which stays set until the host writes to address 1 with bit 1 set. A write with bit 1 clear has no effect. A drop in the same cycle as a clear leaves the flag set.
- R8: After reset the status word reads 1: empty, fill count 0, overflow clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also advances the timebase |
| rst | input | 1 | Synchronous reset, active high |
| pps_in | input | N_CH (5) | Asynchronous pulse inputs, one per channel |
| bus_addr | input | 1 | Register select: 0 data, 1 status |
| bus_rd | input | 1 | Read strobe; a read of address 0 pops one entry |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | ID_W+TS_W (35) | Write data; bit 1 at address 1 clears overflow |
| bus_rdata | output | ID_W+TS_W (35) | Read data, valid in the cycle of the read strobe |

## Verification
The hardest situation to reach from the ports is a write being dropped while the FIFO is full and edges are still pending. Reaching it takes 16 stored entries and no reads, then one more edge. The bench fills the queue with three rounds of simultaneous edges on all five channels, plus one single edge. It then fires one more channel and checks that the fill count stays at 16, that the overflow flag sets and survives a write of 0, and that the stored entries, in order, are the first sixteen.

// File: rtl/pps_ts_pkg.sv
package pps_ts_pkg;
  // host register map
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_STAT = 1'b1;
  // status word layout
  localparam int ST_EMPTY_BIT = 0;
  localparam int ST_OVF_BIT   = 1;
  localparam int ST_FILL_LSB  = 8;
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int N_CH = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] async_in,
  output logic [N_CH-1:0] rise_o
);
  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_chan
      logic meta_q, sync_q, prev_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          meta_q <= 1'b0;
          sync_q <= 1'b0;
          prev_q <= 1'b0;
        end else begin
          meta_q <= async_in[g];
          sync_q <= meta_q;
          prev_q <= sync_q;
        end
      end
      assign rise_o[g] = sync_q & ~prev_q;
    end
  endgenerate
endmodule

// File: rtl/pps_capture.sv
module pps_capture #(
  parameter int N_CH = 5,
  parameter int TS_W = 32,
  parameter int ID_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N_CH-1:0] rise_i,
  input  logic [TS_W-1:0] ts_now,
  output logic [N_CH-1:0] pend_o,
  output logic [N_CH-1:0] grant_o,
  output logic            wr_valid,
  output logic [ID_W-1:0] wr_id,
  output logic [TS_W-1:0] wr_ts
);
  // isolate lowest set bit: lowest channel number wins
  function automatic logic [N_CH-1:0] lowest_one(input logic [N_CH-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  function automatic logic [ID_W-1:0] onehot_to_id(input logic [N_CH-1:0] oh);
    logic [ID_W-1:0] id;
    id = '0;
    for (int i = 0; i < N_CH; i++)
      if (oh[i]) id = ID_W'(i);
    return id;
  endfunction

  logic [N_CH-1:0] pend_q;
  logic [TS_W-1:0] slot_q [N_CH];

  assign grant_o  = lowest_one(pend_q);
  assign pend_o   = pend_q;
  assign wr_valid = |pend_q;
  assign wr_id    = onehot_to_id(grant_o);

  always_comb begin
    wr_ts = '0;
    for (int i = 0; i < N_CH; i++)
      if (grant_o[i]) wr_ts = slot_q[i];
  end

  genvar g;
  generate
    for (g = 0; g < N_CH; g++) begin : g_slot
      always_ff @(posedge clk) begin
        if (rst) begin
          pend_q[g] <= 1'b0;
          slot_q[g] <= '0;
        end else if (rise_i[g] && (!pend_q[g] || grant_o[g])) begin
          pend_q[g] <= 1'b1;
          slot_q[g] <= ts_now;
        end else if (grant_o[g]) begin
          pend_q[g] <= 1'b0;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/pps_fifo.sv
module pps_fifo #(
  parameter int W     = 35,
  parameter int DEPTH = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] fill,
  output logic             empty,
  output logic             drop
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] fill_q;
  logic             full, do_pop, do_push;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (fill_q == '0);
  assign full    = (fill_q == CNT_W'(DEPTH));
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && !do_push;
  assign head    = mem_q[rd_ptr_q];
  assign fill    = fill_q;

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   fill_q <= fill_q + 1'b1;
        2'b01:   fill_q <= fill_q - 1'b1;
        default: fill_q <= fill_q;
      endcase
    end
  end
endmodule

// File: rtl/pps_timestamper.sv
module pps_timestamper #(
  parameter int N_CH  = 5,
  parameter int TS_W  = 32,
  parameter int DEPTH = 16,
  localparam int ID_W   = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int DATA_W = ID_W + TS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_CH-1:0]   pps_in,
  input  logic              bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  import pps_ts_pkg::*;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [TS_W-1:0]   tb_cnt_q;
  logic [N_CH-1:0]   rise_vec, pend_vec, grant_vec;
  logic              cap_valid;
  logic [ID_W-1:0]   cap_id;
  logic [TS_W-1:0]   cap_ts;
  logic [DATA_W-1:0] fifo_head;
  logic [CNT_W-1:0]  fifo_fill;
  logic              fifo_empty, fifo_drop, host_pop, ovf_clr, ovf_q;
  logic [DATA_W-1:0] status_word;

  always_ff @(posedge clk) begin
    if (rst) tb_cnt_q <= '0;
    else     tb_cnt_q <= tb_cnt_q + 1'b1;
  end

  pps_edge_sync #(.N_CH(N_CH)) u_sync (
    .clk(clk), .rst(rst), .async_in(pps_in), .rise_o(rise_vec)
  );

  pps_capture #(.N_CH(N_CH), .TS_W(TS_W), .ID_W(ID_W)) u_cap (
    .clk(clk), .rst(rst), .rise_i(rise_vec), .ts_now(tb_cnt_q),
    .pend_o(pend_vec), .grant_o(grant_vec),
    .wr_valid(cap_valid), .wr_id(cap_id), .wr_ts(cap_ts)
  );

  assign host_pop = bus_rd && (bus_addr == ADDR_DATA);

  pps_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst),
    .push(cap_valid), .push_data({cap_id, cap_ts}),
    .pop(host_pop), .head(fifo_head), .fill(fifo_fill),
    .empty(fifo_empty), .drop(fifo_drop)
  );

  assign ovf_clr = bus_wr && (bus_addr == ADDR_STAT) && bus_wdata[ST_OVF_BIT];

  always_ff @(posedge clk) begin
    if (rst)            ovf_q <= 1'b0;
    else if (fifo_drop) ovf_q <= 1'b1;
    else if (ovf_clr)   ovf_q <= 1'b0;
  end

  always_comb begin
    status_word = '0;
    status_word[ST_EMPTY_BIT] = fifo_empty;
    status_word[ST_OVF_BIT]   = ovf_q;
    status_word[ST_FILL_LSB +: CNT_W] = fifo_fill;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_addr == ADDR_STAT) bus_rdata = status_word;
      else if (!fifo_empty)      bus_rdata = fifo_head;
    end
  end
endmodule

// File: rtl/pps_ts_checker.sv
module pps_ts_checker #(
  parameter int N_CH  = 5,
  parameter int TS_W  = 32,
  parameter int DEPTH = 16,
  parameter int DATA_W = 35,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [TS_W-1:0]   cnt,
  input logic [N_CH-1:0]   rise_vec,
  input logic [N_CH-1:0]   pend_vec,
  input logic [N_CH-1:0]   grant_vec,
  input logic              drop,
  input logic              ovf,
  input logic [CNT_W-1:0]  fill,
  input logic              empty,
  input logic              bus_rd,
  input logic              bus_addr,
  input logic [DATA_W-1:0] bus_rdata
);
  assert_cnt_step_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> cnt == $past(cnt) + 1'b1);

  assert_edge_pends_R3: assert property (@(posedge clk) disable iff (rst)
    (rise_vec != '0) |=> ((pend_vec & $past(rise_vec)) == $past(rise_vec)));

  assert_grant_single_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_vec));

  assert_grant_lowest_R4: assert property (@(posedge clk) disable iff (rst)
    (grant_vec != '0) |-> ((pend_vec & (grant_vec - 1'b1)) == '0));

  assert_fill_bound_R5: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(DEPTH));

  assert_empty_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_addr && empty) |-> (bus_rdata == '0));

  assert_empty_no_pop_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !bus_addr && empty) |=> (fill <= 1));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    drop |=> ovf);
endmodule

bind pps_timestamper pps_ts_checker #(
  .N_CH(N_CH), .TS_W(TS_W), .DEPTH(DEPTH), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst(rst), .cnt(tb_cnt_q), .rise_vec(rise_vec),
  .pend_vec(pend_vec), .grant_vec(grant_vec), .drop(fifo_drop),
  .ovf(ovf_q), .fill(fifo_fill), .empty(fifo_empty),
  .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_rdata(bus_rdata)
);

// File: tb/pps_timestamper_bench.sv
module pps_timestamper_bench;
  localparam int N_CH = 5;
  localparam int DW   = 35;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N_CH-1:0] pps_in = '0;
  logic          bus_addr = 1'b0;
  logic          bus_rd = 1'b0;
  logic          bus_wr = 1'b0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  longint cyc = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  pps_timestamper u_pps_timestamper (
    .clk(clk), .rst(rst), .pps_in(pps_in), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata)
  );

  function automatic logic [DW-1:0] entry(input int id, input longint ts);
    return {3'(id), 32'(ts)};
  endfunction

  function automatic logic [DW-1:0] stat(input int fill, input bit ovf, input bit emp);
    logic [DW-1:0] s;
    s = '0;
    s[0] = emp;
    s[1] = ovf;
    s[12:8] = 5'(fill);
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_read(input logic a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // raise the masked inputs, hold, release; returns cycle of rise
  task automatic pulse(input logic [N_CH-1:0] mask, input int hold, output longint c);
    @(negedge clk);
    c = cyc;
    pps_in = pps_in | mask;
    repeat (hold) @(negedge clk);
    pps_in = pps_in & ~mask;
    repeat (6) @(negedge clk);
  endtask

  task automatic expect_status(input string req, input int fill, input bit ovf);
    logic [DW-1:0] d, e;
    e = stat(fill, ovf, fill == 0);
    bus_read(1'b1, d);
    check(d == e, req, d, e);
  endtask

  task automatic expect_pop(input string req, input logic [DW-1:0] e);
    logic [DW-1:0] d;
    bus_read(1'b0, d);
    check(d == e, req, d, e);
  endtask

  task automatic t_reset;
    // R8 reset status, R6 empty read returns zero without popping
    expect_status("R8 reset status", 0, 0);
    expect_pop("R6 empty read returns 0", '0);
    expect_status("R6 empty read no pop", 0, 0);
  endtask

  task automatic t_single;
    longint c;
    // R1 absolute timestamp, R2 long high gives one sample
    pulse(5'b00100, 30, c);
    expect_status("R2 one sample per rise", 1, 0);
    expect_pop("R1 timestamp c+2 on ch2", entry(2, c + 2));
    expect_status("R6 pop empties FIFO", 0, 0);
  endtask

  task automatic t_spacing;
    longint c0, c3;
    // R3 two channels 7 cycles apart
    @(negedge clk);
    c0 = cyc;
    pps_in[0] = 1'b1;
    repeat (7) @(negedge clk);
    c3 = cyc;
    pps_in[3] = 1'b1;
    repeat (5) @(negedge clk);
    pps_in = '0;
    repeat (6) @(negedge clk);
    check(c3 - c0 == 7, "R3 bench spacing", DW'(c3 - c0), DW'(7));
    expect_pop("R3 first edge ch0", entry(0, c0 + 2));
    expect_pop("R3 second edge ch3 +7", entry(3, c0 + 9));
  endtask

  task automatic t_simul;
    longint c;
    // R4 simultaneous edges drained ascending with equal stamps
    pulse(5'b10110, 5, c);
    expect_status("R4 three entries queued", 3, 0);
    expect_pop("R4 ch1 first", entry(1, c + 2));
    expect_pop("R4 ch2 second", entry(2, c + 2));
    expect_pop("R4 ch4 third", entry(4, c + 2));
  endtask

  task automatic t_overflow;
    longint c;
    logic [DW-1:0] exp_q [16];
    int n = 0;
    // R5 fill to 16, R7 drop and sticky flag
    for (int r = 0; r < 3; r++) begin
      pulse(5'b11111, 4, c);
      for (int ch = 0; ch < 5; ch++) begin
        exp_q[n] = entry(ch, c + 2);
        n++;
      end
    end
    pulse(5'b00001, 4, c);
    exp_q[n] = entry(0, c + 2);
    expect_status("R5 full at 16", 16, 0);
    pulse(5'b00010, 4, c);
    expect_status("R7 drop sets overflow", 16, 1);
    bus_write(1'b1, DW'(0));
    expect_status("R7 write 0 keeps overflow", 16, 1);
    bus_write(1'b1, DW'(2));
    expect_status("R7 write 1 clears overflow", 16, 0);
    for (int i = 0; i < 16; i++)
      expect_pop($sformatf("R5 FIFO order entry %0d", i), exp_q[i]);
    expect_status("R5 drained empty", 0, 0);
  endtask

  task automatic t_partial;
    longint c1, c2;
    // R5 fill count tracks pushes and pops, R3 stamps across rounds
    pulse(5'b01000, 4, c1);
    pulse(5'b00001, 4, c2);
    expect_status("R5 fill count 2", 2, 0);
    expect_pop("R3 ch3 round", entry(3, c1 + 2));
    expect_status("R5 fill count 1", 1, 0);
    expect_pop("R3 ch0 later round", entry(0, c2 + 2));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_single();
    t_spacing();
    t_simul();
    t_partial();
    t_overflow();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule